// File: doc/BRIEF.md
# DDR Self-Refresh Entry and Exit Sequencer

This block takes a DDR SDRAM controller into the low-power self-refresh state and brings it back out. An entry request is accepted only from the idle state. If some bank is still open, the request is held until the bank-idle indication rises. The sequencer then issues one refresh command with the clock-enable pin low. It keeps that pin low, and keeps the chip deselected, for as long as the memory stays in self refresh.

The exit follows a fixed order. The block waits for the system to report a stable clock, then raises the clock enable. It sends only NOP commands for a programmable wake-up count, so that any internal refresh still in progress can finish. Next it writes the base mode register with the DLL-reset bit set. Reads stay blocked until the DLL has had a fixed number of clocks to relock. A request to leave self refresh has no effect in any state other than self refresh itself. All outputs are registered and change one clock after the state decision that causes them.

Top module: `sr_seq`

## Requirements
- R1: Reset state: NOP on the command pins ({cs_n,ras_n,cas_n,we_n} = 0111), cke high, ba and addr zero, busy low, in_self_refresh low, read_allowed high.
- R2: An enter_req seen in idle while banks_idle is high gives, one clock later, the refresh encoding {cs_n,ras_n,cas_n,we_n} = 0001 with cke low, busy high and read_allowed low.
- R3: An enter_req seen in idle while banks_idle is low is held. Outputs stay idle until banks_idle is seen high, and the refresh command appears one clock after that.
- R4: After the entry command, cke stays low and cs_n stays high, with in_self_refresh high, until exit_req is seen.
- R5: After exit_req, cke stays low for as long as clk_stable is low.
- R6: One clock after clk_stable is seen, cke goes high. NOP (0111) is driven for exactly max(txsnr_cycles, 1) cycles.
- R7: The wake-up NOPs are followed by a single load-mode command (0000). It carries ba = 00 and addr with only bit DLL_RST_BIT (default 8) set, which gives 256.
- R8: After the load-mode cycle, NOP is driven with read_allowed low and busy high for exactly LOCK_CYC (default 200) cycles. Then read_allowed rises and busy falls.
- R9: exit_req has no effect in any state other than self refresh. In idle, the outputs stay in their idle values.
- R10: in_self_refresh is high exactly when cke is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| enter_req | input | 1 | Request to enter self refresh |
| exit_req | input | 1 | Request to leave self refresh |
| clk_stable | input | 1 | Memory clock is stable |
| banks_idle | input | 1 | All banks are precharged |
| txsnr_cycles | input | XSNR_W | Wake-up NOP count, sampled when clk_stable is accepted |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BANK_W | Bank address |
| addr | output | ADDR_W | Address / mode op-code |
| busy | output | 1 | Sequence in progress (not idle) |
| in_self_refresh | output | 1 | Memory held in self refresh |
| read_allowed | output | 1 | DLL relocked, reads permitted |

## Verification
The hardest case to reach from the ports is the boundary of the shared down-counter. The count must be exact: a wake-up length of zero must collapse to one cycle, and the 200-cycle lock window must end on exactly the right clock. The bench walks a table of wake-up counts, including zero, one and larger values, through complete entry and exit cycles. In each cycle it counts NOP and lockout cycles at the pins. A separate pass holds banks_idle low and clk_stable low for several cycles, which exercises the pending-entry and clock-wait holds.

// File: rtl/sr_seq_pkg.sv
package sr_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_ENTER     = 3'd1,
    ST_IN_SR     = 3'd2,
    ST_WAIT_CLK  = 3'd3,
    ST_XSNR_NOP  = 3'd4,
    ST_DLL_RESET = 3'd5,
    ST_DLL_LOCK  = 3'd6
  } sr_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  typedef logic [3:0] sdr_cmd_t;

  localparam sdr_cmd_t CMD_NOP     = 4'b0111;
  localparam sdr_cmd_t CMD_DESEL   = 4'b1111;
  localparam sdr_cmd_t CMD_REFRESH = 4'b0001;
  localparam sdr_cmd_t CMD_LOADMR  = 4'b0000;

endpackage

// File: rtl/sr_seq_timer.sv
module sr_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - W'(1);
  end

  assign zero = (cnt_q == '0);

  // R6 / R8: the sequencer never asks for a count below zero
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
    dec |-> (cnt_q != '0));

endmodule

// File: rtl/sr_seq_fsm.sv
module sr_seq_fsm
  import sr_seq_pkg::*;
#(
  parameter int XW       = 8,
  parameter int TW       = 8,
  parameter int LOCK_CYC = 200
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enter_req,
  input  logic          exit_req,
  input  logic          clk_stable,
  input  logic          banks_idle,
  input  logic [XW-1:0] txsnr_cycles,
  input  logic          tmr_zero,
  output sr_state_e     state_d,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          tmr_dec
);

  localparam logic [TW-1:0] LOCK_LOAD = TW'(LOCK_CYC - 1);

  sr_state_e     state_q;
  logic          pend_q;
  logic [TW-1:0] xs_ext;

  always_comb begin
    xs_ext            = '0;
    xs_ext[XW-1:0]    = txsnr_cycles;
  end

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    tmr_dec  = 1'b0;
    unique case (state_q)
      ST_IDLE:      if ((enter_req || pend_q) && banks_idle) state_d = ST_ENTER;
      ST_ENTER:     state_d = ST_IN_SR;
      ST_IN_SR:     if (exit_req) state_d = ST_WAIT_CLK;
      ST_WAIT_CLK:  if (clk_stable) begin
                      state_d  = ST_XSNR_NOP;
                      tmr_load = 1'b1;
                      tmr_val  = (xs_ext == '0) ? '0 : xs_ext - TW'(1);
                    end
      ST_XSNR_NOP:  if (tmr_zero) state_d = ST_DLL_RESET;
                    else          tmr_dec = 1'b1;
      ST_DLL_RESET: begin
                      state_d  = ST_DLL_LOCK;
                      tmr_load = 1'b1;
                      tmr_val  = LOCK_LOAD;
                    end
      ST_DLL_LOCK:  if (tmr_zero) state_d = ST_IDLE;
                    else          tmr_dec = 1'b1;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE) pend_q <= (enter_req || pend_q) && !banks_idle;
      else                    pend_q <= 1'b0;
    end
  end

  // R3: no entry while banks are still open
  a_r3_hold_until_idle: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !banks_idle) |=> (state_q == ST_IDLE));

  // R5: the exit waits for a stable clock
  a_r5_wait_for_clock: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT_CLK && !clk_stable) |=> (state_q == ST_WAIT_CLK));

  // R8: the lock window is not cut short
  a_r8_lock_window: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DLL_LOCK && !tmr_zero) |=> (state_q == ST_DLL_LOCK));

  // R9: idle only leaves towards entry
  a_r9_exit_ignored: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |=> (state_q == ST_IDLE || state_q == ST_ENTER));

endmodule

// File: rtl/sr_seq_outreg.sv
module sr_seq_outreg
  import sr_seq_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int BANK_W      = 2,
  parameter int DLL_RST_BIT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  sr_state_e         state_d,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BANK_W-1:0] ba,
  output logic [ADDR_W-1:0] addr,
  output logic              busy,
  output logic              in_self_refresh,
  output logic              read_allowed
);

  localparam logic [ADDR_W-1:0] DLL_OPCODE = ADDR_W'(1) << DLL_RST_BIT;

  sdr_cmd_t          cmd_d;
  logic              cke_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    cmd_d  = CMD_NOP;
    cke_d  = 1'b1;
    addr_d = '0;
    unique case (state_d)
      ST_ENTER:     begin cmd_d = CMD_REFRESH; cke_d = 1'b0; end
      ST_IN_SR,
      ST_WAIT_CLK:  begin cmd_d = CMD_DESEL;   cke_d = 1'b0; end
      ST_DLL_RESET: begin cmd_d = CMD_LOADMR;  addr_d = DLL_OPCODE; end
      default:      cmd_d = CMD_NOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {cs_n, ras_n, cas_n, we_n} <= CMD_NOP;
      cke             <= 1'b1;
      ba              <= '0;
      addr            <= '0;
      busy            <= 1'b0;
      in_self_refresh <= 1'b0;
      read_allowed    <= 1'b1;
    end else begin
      {cs_n, ras_n, cas_n, we_n} <= cmd_d;
      cke             <= cke_d;
      ba              <= '0;
      addr            <= addr_d;
      busy            <= (state_d != ST_IDLE);
      in_self_refresh <= !cke_d;
      read_allowed    <= (state_d == ST_IDLE);
    end
  end

  // R2: clock enable only drops together with the refresh encoding
  a_r2_entry_cmd: assert property (@(posedge clk) disable iff (rst)
    $fell(cke) |-> ({cs_n, ras_n, cas_n, we_n} == CMD_REFRESH));

  // R6: the first cycle with the clock enable back up is a NOP
  a_r6_nop_after_wake: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> ({cs_n, ras_n, cas_n, we_n} == CMD_NOP));

endmodule

// File: rtl/sr_seq.sv
module sr_seq
  import sr_seq_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int BANK_W      = 2,
  parameter int XSNR_W      = 8,
  parameter int LOCK_CYC    = 200,
  parameter int DLL_RST_BIT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enter_req,
  input  logic              exit_req,
  input  logic              clk_stable,
  input  logic              banks_idle,
  input  logic [XSNR_W-1:0] txsnr_cycles,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BANK_W-1:0] ba,
  output logic [ADDR_W-1:0] addr,
  output logic              busy,
  output logic              in_self_refresh,
  output logic              read_allowed
);

  localparam int LOCK_W = $clog2(LOCK_CYC + 1);
  localparam int TMR_W  = (XSNR_W > LOCK_W) ? XSNR_W : LOCK_W;

  sr_state_e        state_d;
  logic             tmr_load, tmr_dec, tmr_zero;
  logic [TMR_W-1:0] tmr_val;

  sr_seq_fsm #(
    .XW(XSNR_W), .TW(TMR_W), .LOCK_CYC(LOCK_CYC)
  ) fsm_i (
    .clk(clk), .rst(rst),
    .enter_req(enter_req), .exit_req(exit_req),
    .clk_stable(clk_stable), .banks_idle(banks_idle),
    .txsnr_cycles(txsnr_cycles), .tmr_zero(tmr_zero),
    .state_d(state_d), .tmr_load(tmr_load),
    .tmr_val(tmr_val), .tmr_dec(tmr_dec)
  );

  sr_seq_timer #(.W(TMR_W)) timer_i (
    .clk(clk), .rst(rst), .load(tmr_load),
    .load_val(tmr_val), .dec(tmr_dec), .zero(tmr_zero)
  );

  sr_seq_outreg #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .DLL_RST_BIT(DLL_RST_BIT)
  ) outreg_i (
    .clk(clk), .rst(rst), .state_d(state_d),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .busy(busy),
    .in_self_refresh(in_self_refresh), .read_allowed(read_allowed)
  );

endmodule

// File: tb/sr_seq_tb_top.sv
`timescale 1ns/1ps
module sr_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        enter_req, exit_req, clk_stable, banks_idle;
  logic [7:0]  txsnr_cycles;
  logic        cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [12:0] addr;
  logic        busy, in_self_refresh, read_allowed;

  int nchk = 0;
  int nerr = 0;

  localparam int NROWS = 5;
  localparam int XS_IN  [NROWS] = '{1, 0, 3, 7, 20};
  localparam int XS_EXP [NROWS] = '{1, 1, 3, 7, 20};

  always #4 clk = ~clk;

  sr_seq dut_i (
    .clk(clk), .rst(rst), .enter_req(enter_req), .exit_req(exit_req),
    .clk_stable(clk_stable), .banks_idle(banks_idle),
    .txsnr_cycles(txsnr_cycles), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .busy(busy),
    .in_self_refresh(in_self_refresh), .read_allowed(read_allowed)
  );

  function automatic int cmd();
    return int'({cs_n, ras_n, cas_n, we_n});
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_enter();
    enter_req = 1'b1;
    tick();
    enter_req = 1'b0;
    chk("R2 refresh cmd", cmd(), 4'b0001);
    chk("R2 cke low", int'(cke), 0);
    chk("R2 busy", int'(busy), 1);
    chk("R2 read blocked", int'(read_allowed), 0);
  endtask

  task automatic do_exit(input int exp_nops);
    int n;
    int m;
    int bad;
    repeat (3) begin
      tick();
      chk("R4 deselect", int'(cs_n), 1);
      chk("R4 cke low", int'(cke), 0);
      chk("R10 sr flag", int'(in_self_refresh), int'(!cke));
    end
    clk_stable = 1'b0;
    exit_req   = 1'b1;
    tick();
    exit_req   = 1'b0;
    repeat (3) begin
      chk("R5 cke waits", int'(cke), 0);
      tick();
    end
    chk("R5 still low", int'(cke), 0);
    clk_stable = 1'b1;
    tick();
    chk("R10 sr flag wake", int'(in_self_refresh), int'(!cke));
    n = 0;
    while (cke && cmd() == 4'b0111 && n < 1000) begin
      n++;
      tick();
    end
    chk("R6 wake nop count", n, exp_nops);
    chk("R7 load mode cmd", cmd(), 4'b0000);
    chk("R7 bank", int'(ba), 0);
    chk("R7 opcode", int'(addr), 256);
    clk_stable = 1'b0;
    tick();
    m = 0;
    bad = 0;
    while (busy && m < 1000) begin
      if (read_allowed || cmd() != 4'b0111) bad++;
      m++;
      tick();
    end
    chk("R8 lock length", m, 200);
    chk("R8 lock blocks reads", bad, 0);
    chk("R8 read allowed", int'(read_allowed), 1);
  endtask

  initial begin
    rst = 1'b1; enter_req = 1'b0; exit_req = 1'b0;
    clk_stable = 1'b0; banks_idle = 1'b1; txsnr_cycles = 8'd0;
    repeat (3) tick();
    rst = 1'b0;
    chk("R1 cmd", cmd(), 4'b0111);
    chk("R1 cke", int'(cke), 1);
    chk("R1 busy", int'(busy), 0);
    chk("R1 sr flag", int'(in_self_refresh), 0);
    chk("R1 read allowed", int'(read_allowed), 1);
    chk("R1 addr", int'(addr), 0);

    // R9: exit while idle
    exit_req = 1'b1;
    repeat (3) begin
      tick();
      chk("R9 busy", int'(busy), 0);
      chk("R9 cke", int'(cke), 1);
      chk("R9 cmd", cmd(), 4'b0111);
    end
    exit_req = 1'b0;

    for (int i = 0; i < NROWS; i++) begin
      txsnr_cycles = 8'(XS_IN[i]);
      do_enter();
      do_exit(XS_EXP[i]);
    end

    // R3: pending entry while banks busy
    banks_idle = 1'b0;
    enter_req  = 1'b1;
    tick();
    enter_req  = 1'b0;
    repeat (4) begin
      tick();
      chk("R3 held cke", int'(cke), 1);
      chk("R3 held cmd", cmd(), 4'b0111);
      chk("R3 held busy", int'(busy), 0);
    end
    banks_idle = 1'b1;
    tick();
    chk("R3 refresh cmd", cmd(), 4'b0001);
    chk("R3 cke low", int'(cke), 0);
    txsnr_cycles = 8'd2;
    do_exit(2);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule